// File: doc/BRIEF.md
# Indexed Slot Register Access Port

This block sits between a host I/O bus and the configuration storage of a card-slot controller. The host sees a small group of byte-wide I/O ports arranged as pairs. In each pair the even address is an index port and the odd address is a data port. To reach a controller register, the host first writes the register number to the index port. It then reads or writes the data port, and that access lands on the register the index points at.

Each port pair owns a 256-byte register file, and four slots share that file. A slot's registers begin at internal address (slot mod 4) times 0x40, so the upper two index bits pick the slot and the lower six bits pick the register within it. Slots 0 to 3 are reached through the first pair and slots 4 to 7 through the second pair. A 16-bit quantity is stored as two neighbouring bytes with the low byte first. Software moves such a value with two index/data transactions.

The block only decodes host cycles, keeps one index latch per pair and stores bytes. It does nothing with the stored values.

Top module: `slotidx_port`

## Requirements
- R1: On reset every index latch and every stored byte become 0x00. After reset, reads of any index port and any data port return 0x00.
- R2: A read of an index port (0x3E0 for the first pair, 0x3E2 for the second pair) returns the last byte written to that same index port.
- R3: A data port (0x3E1 for the first pair, 0x3E3 for the second pair) reads and writes the byte at the internal address currently held in its pair's index latch.
- R4: A read returns the addressed byte combinationally, in the same cycle that the read strobe is high. Repeated reads of one address with no write in between return the same value.
- R5: Index values that differ only in bits 7:6 select different slot blocks at 0x40 spacing. A byte written in one slot block does not appear in another slot block.
- R6: The two port pairs keep separate index latches and separate register files. A write through one pair never changes what the other pair returns.
- R7: A 16-bit value written as low byte at index k and high byte at index k+1, in two index/data transactions, reads back byte by byte unchanged.
- R8: A host access to an address outside 0x3E0..0x3E3 is ignored. The output enable stays low, the read data is 0x00, and no index latch or stored byte changes.
- R9: A write to either port takes effect at the clock edge that samples the strobe. A read in the same cycle as the write still returns the old value, and reads from the next cycle on return the new value.
- R10: The read-data output enable is high only while the read strobe is high and the address is one of the port addresses. Whenever the enable is low, the read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 16 | Host I/O address |
| ioWr | input | 1 | Host write strobe, one cycle per access |
| ioRd | input | 1 | Host read strobe |
| ioWdata | input | 8 | Host write data |
| ioRdata | output | 8 | Read data, 0x00 when not driven |
| ioRdataOe | output | 1 | High while the block drives read data |

## Verification
A corrupted index latch shows up on the very next index-port read, and every later data-port access then lands on the wrong byte. A decode fault that mixes up the pairs or the slot offsets shows up on the first readback through the other pair or the other slot block, where a value that should be isolated either appears or goes missing. A write that commits one edge late, or lands at the wrong address, shows up on the first read after the write edge. Because reads are combinational, every such fault is visible at the ports within one cycle of the access that exposes it.

// File: rtl/slotidx_pkg.sv
package slotidx_pkg;
  // Width of the port-pair selector carried in the strobe bundle
  localparam int PAIR_SEL_W = 2;

  typedef struct packed {
    logic                  idxWr;
    logic                  idxRd;
    logic                  dataWr;
    logic                  dataRd;
    logic [PAIR_SEL_W-1:0] pair;
  } portStrobe_t;
endpackage

// File: rtl/slotidx_decode.sv
module slotidx_decode
  import slotidx_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                NUM_PAIRS = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03E0
) (
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  output portStrobe_t       strobe
);
  localparam int SPAN = 2 * NUM_PAIRS;

  logic [ADDR_W-1:0] offset;
  logic              hit;
  logic              isData;

  assign offset = ioAddr - BASE_ADDR;
  assign hit    = (ioAddr >= BASE_ADDR) && (offset < ADDR_W'(SPAN));
  assign isData = offset[0];

  always_comb begin
    strobe        = '0;
    strobe.pair   = offset[PAIR_SEL_W:1];
    strobe.idxWr  = hit && ioWr && !isData;
    strobe.idxRd  = hit && ioRd && !isData;
    strobe.dataWr = hit && ioWr && isData;
    strobe.dataRd = hit && ioRd && isData;
  end
endmodule

// File: rtl/slotidx_regfile.sv
module slotidx_regfile
  import slotidx_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] idxQ  [NUM_PAIRS];
  logic [DATA_W-1:0] dataQ [NUM_PAIRS];

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic [DATA_W-1:0] idxReg;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              selP;

    assign selP = (strobe.pair == PAIR_SEL_W'(p));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        idxReg <= '0;
      end else if (selP && strobe.idxWr) begin
        idxReg <= wrData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (selP && strobe.dataWr) begin
        mem[idxReg[IDX_W-1:0]] <= wrData;
      end
    end

    assign idxQ[p]  = idxReg;
    assign dataQ[p] = mem[idxReg[IDX_W-1:0]];
  end

  always_comb begin
    rdData = '0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (strobe.pair == PAIR_SEL_W'(p) && (strobe.idxRd || strobe.dataRd)) begin
        rdData = strobe.idxRd ? idxQ[p] : dataQ[p];
      end
    end
  end
endmodule

// File: rtl/slotidx_port.sv
module slotidx_port
  import slotidx_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                NUM_PAIRS = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03E0,
  parameter int                DATA_W    = 8,
  parameter int                DEPTH     = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [DATA_W-1:0] ioWdata,
  output logic [DATA_W-1:0] ioRdata,
  output logic              ioRdataOe
);
  portStrobe_t       strobe;
  logic [DATA_W-1:0] rdData;

  slotidx_decode #(
    .ADDR_W(ADDR_W), .NUM_PAIRS(NUM_PAIRS), .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd), .strobe(strobe)
  );

  slotidx_regfile #(
    .NUM_PAIRS(NUM_PAIRS), .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(ioWdata), .rdData(rdData)
  );

  assign ioRdataOe = strobe.idxRd || strobe.dataRd;
  assign ioRdata   = ioRdataOe ? rdData : '0;
endmodule

// File: rtl/slotidx_port_chk.sv
module slotidx_port_chk #(
  parameter int                ADDR_W    = 16,
  parameter int                NUM_PAIRS = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03E0,
  parameter int                DATA_W    = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioWr,
  input logic              ioRd,
  input logic [DATA_W-1:0] ioWdata,
  input logic [DATA_W-1:0] ioRdata,
  input logic              ioRdataOe
);
  logic              inRange;
  logic              prevIdxWr;
  logic              prevRd;
  logic              prevWr;
  logic [ADDR_W-1:0] prevAddr;
  logic [DATA_W-1:0] prevWdata;
  logic [DATA_W-1:0] prevRdata;

  assign inRange = (ioAddr >= BASE_ADDR) &&
                   ((ioAddr - BASE_ADDR) < ADDR_W'(2 * NUM_PAIRS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIdxWr <= 1'b0;
      prevRd    <= 1'b0;
      prevWr    <= 1'b0;
      prevAddr  <= '0;
      prevWdata <= '0;
      prevRdata <= '0;
    end else begin
      prevIdxWr <= ioWr && inRange && !ioAddr[0];
      prevRd    <= ioRd;
      prevWr    <= ioWr;
      prevAddr  <= ioAddr;
      prevWdata <= ioWdata;
      prevRdata <= ioRdata;
    end
  end

  // R8
  no_drive_outside_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inRange |-> (!ioRdataOe && ioRdata == '0));

  // R10
  oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioRdataOe |-> ioRd);

  // R2
  index_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prevIdxWr && ioRd && ioAddr == prevAddr) |-> ioRdata == prevWdata);

  // R4
  read_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prevRd && !prevWr && ioRd && inRange && ioAddr == prevAddr) |-> ioRdata == prevRdata);
endmodule

bind slotidx_port slotidx_port_chk #(
  .ADDR_W(ADDR_W), .NUM_PAIRS(NUM_PAIRS), .BASE_ADDR(BASE_ADDR), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/slotidx_port_tb.sv
module slotidx_port_tb;
  typedef struct packed {
    logic        isRd;
    logic [15:0] addr;
    logic [7:0]  data;
    logic        expOe;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h03E0, 8'h05, 1'b0, 8'd2},  // R2 index pair0 = 05
    '{1'b1, 16'h03E0, 8'h05, 1'b1, 8'd2},  // R2 readback
    '{1'b1, 16'h03E1, 8'h00, 1'b1, 8'd1},  // R1 reset content
    '{1'b0, 16'h03E1, 8'hA5, 1'b0, 8'd3},  // R3 data write
    '{1'b1, 16'h03E1, 8'hA5, 1'b1, 8'd3},  // R3
    '{1'b0, 16'h03E2, 8'h05, 1'b0, 8'd6},  // R6 pair1 index
    '{1'b1, 16'h03E3, 8'h00, 1'b1, 8'd6},  // R6 pair1 separate
    '{1'b0, 16'h03E3, 8'h3C, 1'b0, 8'd6},
    '{1'b1, 16'h03E3, 8'h3C, 1'b1, 8'd6},
    '{1'b1, 16'h03E1, 8'hA5, 1'b1, 8'd6},  // R6 pair0 untouched
    '{1'b0, 16'h03E0, 8'h45, 1'b0, 8'd5},  // R5 slot1 reg 05
    '{1'b1, 16'h03E1, 8'h00, 1'b1, 8'd5},
    '{1'b0, 16'h03E1, 8'h77, 1'b0, 8'd5},
    '{1'b0, 16'h03E0, 8'h05, 1'b0, 8'd5},
    '{1'b1, 16'h03E1, 8'hA5, 1'b1, 8'd5},  // R5 slot0 kept
    '{1'b0, 16'h03E0, 8'h45, 1'b0, 8'd5},
    '{1'b1, 16'h03E1, 8'h77, 1'b1, 8'd5},
    '{1'b0, 16'h03E0, 8'h90, 1'b0, 8'd7},  // R7 word 1234, slot2 reg 10
    '{1'b0, 16'h03E1, 8'h34, 1'b0, 8'd7},
    '{1'b0, 16'h03E0, 8'h91, 1'b0, 8'd7},
    '{1'b0, 16'h03E1, 8'h12, 1'b0, 8'd7},
    '{1'b0, 16'h03E0, 8'h90, 1'b0, 8'd7},
    '{1'b1, 16'h03E1, 8'h34, 1'b1, 8'd7},  // R7 low byte
    '{1'b0, 16'h03E0, 8'h91, 1'b0, 8'd7},
    '{1'b1, 16'h03E1, 8'h12, 1'b1, 8'd7},  // R7 high byte
    '{1'b0, 16'h03E4, 8'hFF, 1'b0, 8'd8},  // R8 outside writes
    '{1'b0, 16'h03DF, 8'hEE, 1'b0, 8'd8},
    '{1'b1, 16'h03E4, 8'h00, 1'b0, 8'd8},  // R8 no drive
    '{1'b1, 16'h03DF, 8'h00, 1'b0, 8'd8},
    '{1'b1, 16'h03E0, 8'h91, 1'b1, 8'd8},  // R8 index unchanged
    '{1'b1, 16'h03E1, 8'h12, 1'b1, 8'd8},
    '{1'b1, 16'h03E2, 8'h05, 1'b1, 8'd8},
    '{1'b0, 16'h03E5, 8'h99, 1'b0, 8'd8},
    '{1'b1, 16'h03E3, 8'h3C, 1'b1, 8'd8}   // R8 data unchanged
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [7:0]  ioWdata = '0;
  logic [7:0]  ioRdata;
  logic        ioRdataOe;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  slotidx_port u_dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .ioRdataOe(ioRdataOe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWdata = d; ioWr = 1'b1; ioRd = 1'b0;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic hostRead(input string tag, input logic [15:0] a,
                          input logic [7:0] expD, input logic expOe);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1; ioWr = 1'b0;
    #1;
    chk(tag, ioRdata, expD);
    chk({tag, " oe"}, {7'd0, ioRdataOe}, {7'd0, expOe});
    ioRd = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state at the ports
    hostRead("R1", 16'h03E0, 8'h00, 1'b1);
    hostRead("R1", 16'h03E2, 8'h00, 1'b1);
    hostRead("R1", 16'h03E3, 8'h00, 1'b1);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isRd)
        hostRead($sformatf("R%0d vec%0d", VECS[i].tag, i), VECS[i].addr,
                 VECS[i].data, VECS[i].expOe);
      else
        hostWrite(VECS[i].addr, VECS[i].data);
    end

    // R9 same-cycle read sees old value, next cycle sees new one
    hostWrite(16'h03E0, 8'h20);
    @(negedge clk);
    ioAddr = 16'h03E1; ioWdata = 8'h5A; ioWr = 1'b1; ioRd = 1'b1;
    #1;
    chk("R9 old", ioRdata, 8'h00);
    @(negedge clk);
    ioWr = 1'b0;
    #1;
    chk("R9 new", ioRdata, 8'h5A);
    // R4 combinational read, stable on repeat
    @(negedge clk);
    #1;
    chk("R4 repeat", ioRdata, 8'h5A);

    // R10 no read strobe means no drive
    @(negedge clk);
    ioRd = 1'b0; ioAddr = 16'h03E1;
    #1;
    chk("R10 oe", {7'd0, ioRdataOe}, 8'h00);
    chk("R10 data", ioRdata, 8'h00);

    // R1 mid-run reset clears everything
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    hostRead("R1 idx", 16'h03E0, 8'h00, 1'b1);
    hostWrite(16'h03E0, 8'h91);
    hostRead("R1 data", 16'h03E1, 8'h00, 1'b1);
    hostWrite(16'h03E2, 8'h05);
    hostRead("R1 pair1", 16'h03E3, 8'h00, 1'b1);

    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule